// File: doc/BRIEF.md
# UDP Stream Frame Transmitter for a PHY-Side RGMII Link

This block turns a byte stream from fabric logic into Ethernet frames and drives them toward a host MAC. On that link the FPGA takes the role of the PHY. Every frame holds an IPv4/UDP datagram. Addresses, ports, TTL and protocol come from parameters as a fixed template. Only the two length fields and the IPv4 header checksum are worked out for each frame, from the payload length that the source gives when it offers the first byte. The UDP checksum goes out as zero.

The transmitter sends the preamble and start delimiter, then the 42 header bytes, then the payload. A short payload is zero-padded. The block then appends a CRC-32 frame check and holds the line idle for the inter-frame gap. It keeps no session state: a frame starts whenever data is offered. The link runs at one byte per 125 MHz clock. Each byte leaves as two nibbles, one on each clock edge. The block presents the rising-edge and falling-edge values on separate registered outputs, and external double-data-rate output cells combine them.

Top module: `udp_frame_tx`

## Requirements
- R1: While reset is held, and after it until the first frame, both control outputs, both data nibbles and `pl_ready` are 0.
- R2: A frame opens with seven bytes 0x55 and then one byte 0xD5. The rising-edge control output stays 1 from the first preamble byte to the last check byte, with no gap.
- R3: Byte bits 3:0 appear on `lnk_d_pos` and bits 7:4 on `lnk_d_neg` in the same cycle. `lnk_ctl_neg` equals enable XOR error, so it is 0 only for an error byte, and it is never 1 while `lnk_ctl_pos` is 0.
- R4: After the delimiter come destination MAC, source MAC, type 0x0800, then 0x45 0x00. IPv4 bytes 4..7 are 0x00 0x00 0x40 0x00, then TTL, protocol 0x11, both IPv4 addresses, both UDP ports, and a UDP checksum of 0x0000. All multi-byte fields are sent most significant byte first.
- R5: The IPv4 total length equals payload length + 28 and the UDP length equals payload length + 8. Both are big-endian.
- R6: The IPv4 header checksum is the ones-complement of the ones-complement sum of the ten header words, with the checksum field taken as zero.
- R7: The length `pl_len` is captured when a frame starts. Exactly that many payload bytes follow the header. `pl_ready` is 1 only while payload bytes are still being taken.
- R8: If `pl_last` is accepted before the captured length is reached, `pl_ready` drops on the next cycle and the remaining payload bytes are sent as 0x00.
- R9: If the payload is shorter than 18 bytes, 0x00 bytes follow it so that exactly 60 bytes come between the delimiter and the check.
- R10: The check is CRC-32 (reflected polynomial 0xEDB88320, start value all ones, result inverted). It covers the first destination byte through the last pad byte and is sent least significant byte first.
- R11: At least 12 idle cycles, with the control outputs at 0, separate the end of one frame from the start of the next.
- R12: When the source has no byte ready during the payload, the block sends an error cycle instead: `lnk_ctl_pos`=1, `lnk_ctl_neg`=0, data 0. This cycle does not count as payload and does not enter the CRC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pl_len | input | LEN_W | Payload length of the frame being offered |
| pl_data | input | 8 | Payload byte |
| pl_valid | input | 1 | Source offers a byte (or a frame start) |
| pl_last | input | 1 | Final byte of the source data |
| pl_ready | output | 1 | Byte taken on this edge when valid |
| lnk_d_pos | output | 4 | Data nibble for the rising edge |
| lnk_d_neg | output | 4 | Data nibble for the falling edge |
| lnk_ctl_pos | output | 1 | Control value for the rising edge (enable) |
| lnk_ctl_neg | output | 1 | Control value for the falling edge (enable XOR error) |

## Verification
The bench builds the block with LEN_W = 9 and with non-broadcast addresses, ports and TTL of its own. This shows that every template field comes from the parameters and not from built-in defaults. The 9-bit length allows payloads of up to 511 bytes. The stimulus covers zero, one, seventeen and eighteen bytes around the padding edge, a long frame of 300 bytes, an early end that forces zero fill, a source stall that produces error cycles, and two frames offered back to back so that the gap can be measured.

// File: rtl/udp_tx_pkg.sv
package udp_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_HDR, ST_PAY, ST_PAD, ST_FCS, ST_GAP
  } tx_state_t;

  localparam int PRE_BYTES = 8;
  localparam int HDR_BYTES = 42;
  localparam int MIN_BODY  = 60;
  localparam int MIN_PAY   = MIN_BODY - HDR_BYTES;
  localparam int FCS_BYTES = 4;
  localparam int GAP_BYTES = 12;

  localparam logic [7:0]  PRE_BYTE = 8'h55;
  localparam logic [7:0]  SFD_BYTE = 8'hD5;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  // one byte of the reflected CRC, least significant bit first
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/udp_hdr_rom.sv
module udp_hdr_rom #(
  parameter int          LEN_W    = 11,
  parameter logic [47:0] DST_MAC  = 48'hFFFF_FFFF_FFFF,
  parameter logic [47:0] SRC_MAC  = 48'h0200_0000_0001,
  parameter logic [31:0] SRC_IP   = 32'hC0A8_0102,
  parameter logic [31:0] DST_IP   = 32'hC0A8_0101,
  parameter logic [15:0] SRC_PORT = 16'd5000,
  parameter logic [15:0] DST_PORT = 16'd5001,
  parameter logic [7:0]  TTL      = 8'h40
) (
  input  logic [LEN_W-1:0] len,
  input  logic [5:0]       idx,
  output logic [7:0]       hbyte
);
  import udp_tx_pkg::*;

  localparam int HBITS = HDR_BYTES * 8;

  // sum of every constant IPv4 header word
  localparam logic [31:0] FIXED_SUM =
      32'h0000_4500 + 32'h0000_4000 + {16'h0, TTL, 8'h11} +
      {16'h0, SRC_IP[31:16]} + {16'h0, SRC_IP[15:0]} +
      {16'h0, DST_IP[31:16]} + {16'h0, DST_IP[15:0]};

  logic [15:0]      ip_len, udp_len, ip_sum;
  logic [31:0]      acc;
  logic [16:0]      fold1;
  logic [15:0]      fold2;
  logic [HBITS-1:0] hdr_bits, hdr_sh;
  logic [8:0]       shamt;

  always_comb begin
    ip_len  = 16'(len) + 16'd28;
    udp_len = 16'(len) + 16'd8;
    acc     = FIXED_SUM + {16'h0, ip_len};
    fold1   = {1'b0, acc[15:0]} + {1'b0, acc[31:16]};
    fold2   = fold1[15:0] + {15'h0, fold1[16]};
    ip_sum  = ~fold2;
    hdr_bits = {DST_MAC, SRC_MAC, 16'h0800,
                8'h45, 8'h00, ip_len, 16'h0000, 16'h4000, TTL, 8'h11, ip_sum,
                SRC_IP, DST_IP,
                SRC_PORT, DST_PORT, udp_len, 16'h0000};
    shamt  = 9'd8 * (9'(HDR_BYTES - 1) - {3'b000, idx});
    hdr_sh = hdr_bits >> shamt;
    hbyte  = hdr_sh[7:0];
  end

endmodule

// File: rtl/udp_crc32.sv
module udp_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);
  import udp_tx_pkg::*;

  logic [31:0] crc_d;

  always_comb begin
    crc_d = crc_q;
    if (init)     crc_d = 32'hFFFF_FFFF;
    else if (upd) crc_d = crc_byte(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= 32'hFFFF_FFFF;
    else        crc_q <= crc_d;
  end

endmodule

// File: rtl/udp_nibble_out.sv
module udp_nibble_out (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tx_byte,
  input  logic       tx_en,
  input  logic       tx_er,
  output logic [3:0] d_pos,
  output logic [3:0] d_neg,
  output logic       ctl_pos,
  output logic       ctl_neg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_pos   <= 4'h0;
      d_neg   <= 4'h0;
      ctl_pos <= 1'b0;
      ctl_neg <= 1'b0;
    end else begin
      d_pos   <= tx_byte[3:0];
      d_neg   <= tx_byte[7:4];
      ctl_pos <= tx_en;
      ctl_neg <= tx_en ^ tx_er;
    end
  end
endmodule

// File: rtl/udp_frame_tx.sv
module udp_frame_tx #(
  parameter int          LEN_W       = 11,
  parameter int          SYNC_STAGES = 2,
  parameter logic [47:0] DST_MAC     = 48'hFFFF_FFFF_FFFF,
  parameter logic [47:0] SRC_MAC     = 48'h0200_0000_0001,
  parameter logic [31:0] SRC_IP      = 32'hC0A8_0102,
  parameter logic [31:0] DST_IP      = 32'hC0A8_0101,
  parameter logic [15:0] SRC_PORT    = 16'd5000,
  parameter logic [15:0] DST_PORT    = 16'd5001,
  parameter logic [7:0]  TTL         = 8'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] pl_len,
  input  logic [7:0]       pl_data,
  input  logic             pl_valid,
  input  logic             pl_last,
  output logic             pl_ready,
  output logic [3:0]       lnk_d_pos,
  output logic [3:0]       lnk_d_neg,
  output logic             lnk_ctl_pos,
  output logic             lnk_ctl_neg
);
  import udp_tx_pkg::*;

  localparam int CW = (LEN_W > 6) ? LEN_W : 6;

  // reset: asserted at once, released through a synchronizer
  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_i_n;

  generate
    if (SYNC_STAGES == 1) begin : g_rs1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) rs_q <= '0;
        else        rs_q <= 1'b1;
    end else begin : g_rsn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) rs_q <= '0;
        else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
    end
  endgenerate
  assign rst_i_n = rs_q[SYNC_STAGES-1];

  tx_state_t        st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             fill_q, fill_d;

  logic [7:0]  tx_byte, hdr_byte;
  logic        tx_en, tx_er, crc_init, crc_upd, step;
  logic [31:0] crc_q, crc_sh;
  logic [CW-1:0] len_m1, pad_need, pad_m1;

  udp_hdr_rom #(
    .LEN_W(LEN_W), .DST_MAC(DST_MAC), .SRC_MAC(SRC_MAC), .SRC_IP(SRC_IP),
    .DST_IP(DST_IP), .SRC_PORT(SRC_PORT), .DST_PORT(DST_PORT), .TTL(TTL)
  ) u_hdr (
    .len(len_q), .idx(cnt_q[5:0]), .hbyte(hdr_byte)
  );

  udp_crc32 u_crc (
    .clk(clk), .rst_n(rst_i_n), .init(crc_init), .upd(crc_upd),
    .din(tx_byte), .crc_q(crc_q)
  );

  udp_nibble_out u_out (
    .clk(clk), .rst_n(rst_i_n), .tx_byte(tx_byte), .tx_en(tx_en), .tx_er(tx_er),
    .d_pos(lnk_d_pos), .d_neg(lnk_d_neg), .ctl_pos(lnk_ctl_pos), .ctl_neg(lnk_ctl_neg)
  );

  assign pl_ready = (st_q == ST_PAY) && !fill_q;

  always_comb begin
    len_m1   = CW'(len_q) - CW'(1);
    pad_need = (CW'(len_q) < CW'(MIN_PAY)) ? (CW'(MIN_PAY) - CW'(len_q)) : '0;
    pad_m1   = pad_need - CW'(1);
    crc_sh   = crc_q >> {cnt_q[1:0], 3'b000};
  end

  // next-state process
  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    len_d    = len_q;
    fill_d   = fill_q;
    tx_byte  = 8'h00;
    tx_en    = 1'b0;
    tx_er    = 1'b0;
    crc_init = 1'b0;
    crc_upd  = 1'b0;
    step     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (pl_valid) begin
          len_d = pl_len;
          cnt_d = '0;
          st_d  = ST_PRE;
        end
      end
      ST_PRE: begin
        tx_en    = 1'b1;
        crc_init = 1'b1;
        tx_byte  = (cnt_q == CW'(PRE_BYTES - 1)) ? SFD_BYTE : PRE_BYTE;
        if (cnt_q == CW'(PRE_BYTES - 1)) begin
          cnt_d = '0;
          st_d  = ST_HDR;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_HDR: begin
        tx_en   = 1'b1;
        tx_byte = hdr_byte;
        crc_upd = 1'b1;
        if (cnt_q == CW'(HDR_BYTES - 1)) begin
          cnt_d = '0;
          st_d  = (len_q == '0) ? ST_PAD : ST_PAY;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_PAY: begin
        tx_en = 1'b1;
        if (fill_q) begin
          step = 1'b1;
        end else if (pl_valid) begin
          step    = 1'b1;
          tx_byte = pl_data;
          if (pl_last) fill_d = 1'b1;
        end else begin
          tx_er = 1'b1;
        end
        if (step) begin
          crc_upd = 1'b1;
          if (cnt_q == len_m1) begin
            cnt_d  = '0;
            fill_d = 1'b0;
            st_d   = (pad_need != '0) ? ST_PAD : ST_FCS;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      ST_PAD: begin
        tx_en   = 1'b1;
        crc_upd = 1'b1;
        if (cnt_q == pad_m1) begin
          cnt_d = '0;
          st_d  = ST_FCS;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_FCS: begin
        tx_en   = 1'b1;
        tx_byte = ~crc_sh[7:0];
        if (cnt_q == CW'(FCS_BYTES - 1)) begin
          cnt_d = '0;
          st_d  = ST_GAP;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_GAP: begin
        if (cnt_q == CW'(GAP_BYTES - 1)) begin
          cnt_d = '0;
          st_d  = ST_IDLE;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      len_q  <= '0;
      fill_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      fill_q <= fill_d;
    end
  end

endmodule

// File: rtl/udp_frame_tx_chk.sv
module udp_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic pl_valid,
  input logic pl_last,
  input logic pl_ready,
  input logic lnk_ctl_pos,
  input logic lnk_ctl_neg,
  input logic [3:0] lnk_d_pos,
  input logic [3:0] lnk_d_neg
);
  logic [11:0] run_q;
  logic [7:0]  idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      idle_q <= 8'hFF;
    end else begin
      if (lnk_ctl_pos) begin
        idle_q <= '0;
        if (run_q != 12'hFFF) run_q <= run_q + 12'd1;
      end else begin
        run_q <= '0;
        if (idle_q != 8'hFF) idle_q <= idle_q + 8'd1;
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!lnk_ctl_pos && !lnk_ctl_neg && !pl_ready &&
                                   lnk_d_pos == 4'h0 && lnk_d_neg == 4'h0)
        else $error("R1 outputs active during reset");
    end
  end

  a_r3_err_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_ctl_neg |-> lnk_ctl_pos);

  a_r7_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |=> lnk_ctl_pos);

  a_r8_last_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && pl_ready && pl_last) |=> !pl_ready);

  a_r9_min_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lnk_ctl_pos) |-> (run_q >= 12'd72));

  a_r11_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lnk_ctl_pos) |-> (idle_q >= 8'd12));

endmodule

bind udp_frame_tx udp_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pl_valid(pl_valid), .pl_last(pl_last),
  .pl_ready(pl_ready), .lnk_ctl_pos(lnk_ctl_pos), .lnk_ctl_neg(lnk_ctl_neg),
  .lnk_d_pos(lnk_d_pos), .lnk_d_neg(lnk_d_neg)
);

// File: tb/udp_frame_tx_test.sv
module udp_frame_tx_test;
  localparam int          CLK_NS = 8;
  localparam int          LW     = 9;
  localparam logic [47:0] T_DMAC = 48'h0A1B_2C3D_4E5F;
  localparam logic [47:0] T_SMAC = 48'h0266_7788_99AA;
  localparam logic [31:0] T_SIP  = 32'h0A00_0017;
  localparam logic [31:0] T_DIP  = 32'h0A00_0002;
  localparam logic [15:0] T_SPRT = 16'h1F90;
  localparam logic [15:0] T_DPRT = 16'h2329;
  localparam logic [7:0]  T_TTL  = 8'h21;

  localparam int NV = 6;
  localparam int V_LEN  [NV] = '{0, 1, 17, 18, 300, 46};
  localparam int V_SEND [NV] = '{0, 1, 17, 18, 300, 20};
  localparam int V_SEED [NV] = '{8'h00, 8'hA5, 8'h13, 8'h70, 8'h3C, 8'hE1};

  logic          clk = 1'b0;
  logic          rst_n;
  logic [LW-1:0] pl_len;
  logic [7:0]    pl_data;
  logic          pl_valid, pl_last, pl_ready;
  logic [3:0]    lnk_d_pos, lnk_d_neg;
  logic          lnk_ctl_pos, lnk_ctl_neg;

  udp_frame_tx #(
    .LEN_W(LW), .DST_MAC(T_DMAC), .SRC_MAC(T_SMAC), .SRC_IP(T_SIP), .DST_IP(T_DIP),
    .SRC_PORT(T_SPRT), .DST_PORT(T_DPRT), .TTL(T_TTL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .pl_len(pl_len), .pl_data(pl_data), .pl_valid(pl_valid),
    .pl_last(pl_last), .pl_ready(pl_ready), .lnk_d_pos(lnk_d_pos), .lnk_d_neg(lnk_d_neg),
    .lnk_ctl_pos(lnk_ctl_pos), .lnk_ctl_neg(lnk_ctl_neg)
  );

  always #(CLK_NS/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [7:0] cap [0:1023];
  logic [7:0] expb [0:1023];
  int cap_n = 0, exp_n = 0, err_n = 0, frames_seen = 0;
  int idle_run = 0, min_gap = 1000;
  bit in_frame = 0, seen_any = 0;

  // link monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (lnk_ctl_pos) begin
        if (!in_frame) begin
          if (seen_any && idle_run < min_gap) min_gap = idle_run;
          cap_n = 0; err_n = 0; in_frame = 1;
        end
        if (lnk_ctl_neg) begin
          cap[cap_n] = {lnk_d_neg, lnk_d_pos};
          cap_n++;
        end else begin
          err_n++;
        end
      end else begin
        if (in_frame) begin
          in_frame = 0; seen_any = 1; frames_seen++; idle_run = 0;
        end
        idle_run++;
      end
    end
  end

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed + i * 7 + (i >> 3)) & 255);
  endfunction

  task automatic push(input logic [7:0] b);
    expb[exp_n] = b;
    exp_n++;
  endtask

  task automatic build_exp(input int len, input int nsend, input int seed);
    logic [31:0] c, s;
    logic [7:0]  d;
    int il, ul;
    exp_n = 0;
    for (int k = 0; k < 7; k++) push(8'h55);
    push(8'hD5);
    for (int k = 5; k >= 0; k--) push(T_DMAC[8*k +: 8]);
    for (int k = 5; k >= 0; k--) push(T_SMAC[8*k +: 8]);
    push(8'h08); push(8'h00);
    il = len + 28; ul = len + 8;
    push(8'h45); push(8'h00); push(8'(il >> 8)); push(8'(il));
    push(8'h00); push(8'h00); push(8'h40); push(8'h00);
    push(T_TTL); push(8'h11); push(8'h00); push(8'h00);
    for (int k = 3; k >= 0; k--) push(T_SIP[8*k +: 8]);
    for (int k = 3; k >= 0; k--) push(T_DIP[8*k +: 8]);
    push(T_SPRT[15:8]); push(T_SPRT[7:0]); push(T_DPRT[15:8]); push(T_DPRT[7:0]);
    push(8'(ul >> 8)); push(8'(ul)); push(8'h00); push(8'h00);
    for (int k = 0; k < len; k++) push((k < nsend) ? pat(seed, k) : 8'h00);
    while (exp_n - 8 < 60) push(8'h00);
    s = 0;
    for (int k = 22; k < 42; k += 2) s = s + {16'h0, expb[k], expb[k+1]};
    while (s[31:16] != 0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    expb[32] = ~s[15:8];
    expb[33] = ~s[7:0];
    c = 32'hFFFF_FFFF;
    for (int k = 8; k < exp_n; k++) begin
      d = expb[k];
      for (int b = 0; b < 8; b++) begin
        if (c[0] ^ d[b]) c = (c >> 1) ^ 32'hEDB88320;
        else             c = c >> 1;
      end
    end
    c = ~c;
    for (int k = 0; k < 4; k++) push(c[8*k +: 8]);
  endtask

  task automatic check(input string tag, input bit ok, input int got, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, expv);
    end
  endtask

  task automatic chk_rng(input string tag, input int lo, input int hi);
    int bad = -1;
    for (int k = lo; k <= hi; k++)
      if (bad < 0 && cap[k] !== expb[k]) bad = k;
    nchk++;
    if (bad >= 0) begin
      nfail++;
      $display("FAIL %s byte %0d: got %02h expected %02h", tag, bad, cap[bad], expb[bad]);
    end
  endtask

  task automatic send(input int len, input int nsend, input int seed,
                      input int stall_at, input int stall_n);
    int i = 0;
    int sl = stall_n;
    bit acc;
    @(negedge clk);
    pl_len = LW'(len);
    if (nsend == 0) begin
      pl_valid = 1'b1; pl_last = 1'b0;
      @(negedge clk);
      pl_valid = 1'b0;
    end else begin
      while (i < nsend) begin
        if (i == stall_at && sl > 0) begin
          pl_valid = 1'b0; sl--;
        end else begin
          pl_valid = 1'b1;
        end
        pl_data = pat(seed, i);
        pl_last = (i == nsend - 1);
        acc = pl_valid && pl_ready;
        @(posedge clk);
        if (acc) i++;
        @(negedge clk);
      end
      pl_valid = 1'b0; pl_last = 1'b0;
    end
  endtask

  task automatic verify_frame(input int len);
    int body_end;
    body_end = exp_n - 5;
    check("R2/R7 frame byte count", cap_n == exp_n, cap_n, exp_n);
    chk_rng("R2 preamble/delimiter", 0, 7);
    chk_rng("R4 ethernet header and IPv4 bytes 0..1", 8, 23);
    chk_rng("R5 IPv4 total length", 24, 25);
    chk_rng("R4 IPv4 id/flags/ttl/proto", 26, 31);
    chk_rng("R6 IPv4 checksum", 32, 33);
    chk_rng("R4 addresses and ports", 34, 45);
    chk_rng("R5 UDP length", 46, 47);
    chk_rng("R4 UDP checksum zero", 48, 49);
    if (len > 0) chk_rng("R7/R8 payload", 50, 49 + len);
    if (50 + len <= body_end) chk_rng("R9 padding", 50 + len, body_end);
    chk_rng("R10 frame check", exp_n - 4, exp_n - 1);
    check("R7 ready low after frame", pl_ready == 1'b0, int'(pl_ready), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int target;
    rst_n = 1'b0; pl_valid = 1'b0; pl_last = 1'b0; pl_data = 8'h00; pl_len = '0;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    check("R1 ctl in reset", !lnk_ctl_pos && !lnk_ctl_neg, int'(lnk_ctl_pos), 0);
    check("R1 data in reset", lnk_d_pos == 0 && lnk_d_neg == 0, int'({lnk_d_neg, lnk_d_pos}), 0);
    check("R1 ready in reset", pl_ready == 1'b0, int'(pl_ready), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 idle after reset", !lnk_ctl_pos && !pl_ready, int'(lnk_ctl_pos), 0);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      target = frames_seen + 1;
      build_exp(V_LEN[v], V_SEND[v], V_SEED[v]);
      send(V_LEN[v], V_SEND[v], V_SEED[v], -1, 0);
      wait (frames_seen == target);
      verify_frame(V_LEN[v]);
      check("R3 no error cycles", err_n == 0, err_n, 0);
      repeat (20) @(posedge clk);
    end

    // R12: source stalls three cycles inside the payload
    target = frames_seen + 1;
    build_exp(30, 30, 8'h5A);
    send(30, 30, 8'h5A, 10, 3);
    wait (frames_seen == target);
    check("R12 error cycle count", err_n == 3, err_n, 3);
    verify_frame(30);
    repeat (20) @(posedge clk);

    // R11: two frames offered back to back
    min_gap = 1000;
    target = frames_seen + 2;
    send(40, 40, 8'h11, -1, 0);
    send(20, 20, 8'h22, -1, 0);
    wait (frames_seen == target);
    check("R11 inter-frame gap", min_gap >= 12, min_gap, 12);
    repeat (5) @(posedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule